// File: doc/BRIEF.md
# Address Window Chip Select Decoder

This block turns a 24-bit external bus address into a set of chip-select lines. Four programmable windows can be placed over the address space. Each window has a range register, which holds a start field and a size code, and a control register. Any address that no enabled window claims falls into a default region. The default region has a control register but no range register. Each output can be tied to the read strobe, to the write strobes, or to both, so that a device sees its select only during the command it cares about.

A small register port writes all nine registers and reads them back. The bus address is captured on each clock edge. The chip-select outputs are decoded combinationally from that captured address and from the live strobes. The external-access pin and a 2-bit boot configuration are sampled during reset, and they decide whether the default region comes up active.

Top module: `cs_window_decoder`

## Requirements
- R1: After reset, every range register and every window control register reads 0000h.
- R2: If `ext_access_i` is high during reset, the default control register (register address 0) reads 0000h, and no chip select is asserted.
- R3: If `ext_access_i` is low during reset, the default control register reads `{12'h000, boot_cfg_i, 2'b11}`. This sets the active bit (bit 0) and the latch-control bit (bit 1), and places the boot configuration in the bus-type field (bits 3:2).
- R4: Window i covers 4 KB × 2^n. Here n is the size code in range bits 3:0, and values above 12 are treated as 12. The window contains an address when address bits 23:12+n equal start bits 15:4+n of the range register.
- R5: When several enabled windows contain the address, only the lowest-numbered one asserts its select (`cs_n_o[i]`, where i is 1 to 4).
- R6: A window takes part in decoding only while the active bit (bit 0) of its control register is 1.
- R7: If only the read-gate bit (control bit 4) is set, the selected output is low only while `rd_n_i` is low. If both gate bits are clear, the output is low whenever the region is selected.
- R8: If only the write-gate bit (control bit 5) is set, the selected output is low only while at least one bit of `wr_n_i` is low. If both gate bits are set, either a read or a write asserts it.
- R9: An address that no enabled window contains asserts `cs_n_o[0]`, provided the default active bit is set.
- R10: At most one bit of `cs_n_o` is low at any time. All outputs are active low.
- R11: Start bits that lie below the window size are ignored, so a start value that is not aligned behaves like the aligned value below it.
- R12: A write to an unmapped register address changes no register. Control registers sit at addresses 0 to 4, and range registers for windows 1 to 4 sit at addresses 9 to 12.
- R13: A register write, and a new bus address, both affect the outputs from the next clock edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_access_i | input | 1 | External-access pin, sampled during reset |
| boot_cfg_i | input | 2 | Bus type loaded into the default control register during reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Read data of the addressed register (0 if unmapped) |
| bus_addr_i | input | 24 | External bus address, captured each clock |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 2 | Write strobes for the low and high byte, active low |
| cs_n_o | output | 5 | Chip selects: bit 0 is the default region, bits 1 to 4 are the windows, active low |

## Verification
All 4096 4 KB pages are swept under three register setups, and the expected selects are computed arithmetically from the bench's own copy of the registers. The first setup uses separate windows of several sizes, plus one window that is disabled, so a size error or a wrong enable shows up as pages that land in the wrong region. The second setup uses overlapping and unaligned windows, plus a window that spans the whole space, which separates a wrong priority order from a wrong treatment of the low start bits. The third setup cycles the strobes through idle, read, low-byte write and high-byte write on every page, against windows that are gated by read, by write and by both, so that each gating mode gives a distinct pattern.

// File: rtl/csd_pkg.sv
package csd_pkg;
  // Control register bit positions
  localparam int CTL_ACT  = 0;
  localparam int CTL_ALE  = 1;
  localparam int CTL_BT   = 2;  // 2-bit bus type at [3:2]
  localparam int CTL_RDCS = 4;
  localparam int CTL_WRCS = 5;

  // Qualify a selected region against the command strobes
  function automatic logic strobe_qualify(input logic rd_gate, input logic wr_gate,
                                          input logic rd_act, input logic wr_act);
    return (!rd_gate && !wr_gate) || (rd_gate && rd_act) || (wr_gate && wr_act);
  endfunction
endpackage

// File: rtl/csd_regfile.sv
module csd_regfile
  import csd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int REG_W   = 16,
  parameter int RA_W    = $clog2(NUM_WIN + 1) + 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          ext_access_i,
  input  logic [1:0]                    boot_cfg_i,
  input  logic                          we_i,
  input  logic [RA_W-1:0]               addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [NUM_WIN:0][REG_W-1:0]   ctl_o,
  output logic [NUM_WIN-1:0][REG_W-1:0] rsel_o
);
  localparam int IDX_W = RA_W - 1;

  logic [NUM_WIN:0][REG_W-1:0]   ctl_q;
  logic [NUM_WIN-1:0][REG_W-1:0] rsel_q;
  logic [IDX_W-1:0]              idx;
  logic                          is_rsel, ctl_hit, rsel_hit;

  assign idx      = addr_i[IDX_W-1:0];
  assign is_rsel  = addr_i[RA_W-1];
  assign ctl_hit  = !is_rsel && (int'(idx) <= NUM_WIN);
  assign rsel_hit = is_rsel && (idx != '0) && (int'(idx) <= NUM_WIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 1; i <= NUM_WIN; i++) ctl_q[i] <= '0;
      rsel_q <= '0;
      if (ext_access_i) begin
        ctl_q[0] <= '0;
      end else begin
        ctl_q[0]               <= '0;
        ctl_q[0][CTL_ACT]      <= 1'b1;
        ctl_q[0][CTL_ALE]      <= 1'b1;
        ctl_q[0][CTL_BT +: 2]  <= boot_cfg_i;
      end
    end else if (we_i) begin
      if (ctl_hit)  ctl_q[idx]      <= wdata_i;
      if (rsel_hit) rsel_q[idx - 1] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (ctl_hit)  rdata_o = ctl_q[idx];
    if (rsel_hit) rdata_o = rsel_q[idx - 1];
  end

  assign ctl_o  = ctl_q;
  assign rsel_o = rsel_q;

  // R12
  unmapped_write_chk: assert property (@(posedge clk) disable iff (rst)
    (we_i && !ctl_hit && !rsel_hit) |=> ($stable(ctl_q) && $stable(rsel_q)));
endmodule

// File: rtl/csd_window_match.sv
module csd_window_match #(
  parameter int ADDR_W    = 24,
  parameter int PAGE_LOG2 = 12,
  parameter int SIZE_W    = 4,
  parameter int REG_W     = 16
) (
  input  logic [REG_W-1:0]  rsel_i,
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int START_W = ADDR_W - PAGE_LOG2;

  logic [SIZE_W-1:0]  size_code;
  logic [START_W-1:0] start_f;
  logic               eq;

  assign size_code = rsel_i[SIZE_W-1:0];
  assign start_f   = rsel_i[SIZE_W +: START_W];

  always_comb begin
    eq = 1'b1;
    for (int k = 0; k < START_W; k++) begin
      if (k >= int'(size_code) && addr_i[PAGE_LOG2 + k] != start_f[k]) eq = 1'b0;
    end
  end

  assign hit_o = active_i && eq;
endmodule

// File: rtl/csd_select.sv
module csd_select
  import csd_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int REG_W   = 16
) (
  input  logic [NUM_WIN-1:0]          hit_i,
  input  logic [NUM_WIN:0][REG_W-1:0] ctl_i,
  input  logic                        rd_n_i,
  input  logic [1:0]                  wr_n_i,
  output logic [NUM_WIN:0]            cs_n_o
);
  localparam int SEL_W = $clog2(NUM_WIN + 1);

  logic [SEL_W-1:0] sel;
  logic             found, region_on, qual;
  logic [REG_W-1:0] c;

  always_comb begin
    sel   = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (!found && hit_i[i]) begin
        sel   = SEL_W'(i + 1);
        found = 1'b1;
      end
    end
    c         = ctl_i[sel];
    region_on = found || ctl_i[0][CTL_ACT];
    qual      = strobe_qualify(c[CTL_RDCS], c[CTL_WRCS], !rd_n_i, !(&wr_n_i));
    cs_n_o    = '1;
    if (region_on && qual) cs_n_o[sel] = 1'b0;
  end
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import csd_pkg::*;
#(
  parameter int NUM_WIN   = 4,
  parameter int ADDR_W    = 24,
  parameter int PAGE_LOG2 = 12,
  parameter int SIZE_W    = 4,
  parameter int REG_W     = 16,
  parameter int RA_W      = $clog2(NUM_WIN + 1) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_access_i,
  input  logic [1:0]        boot_cfg_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              rd_n_i,
  input  logic [1:0]        wr_n_i,
  output logic [NUM_WIN:0]  cs_n_o
);
  logic [NUM_WIN:0][REG_W-1:0]   ctl;
  logic [NUM_WIN-1:0][REG_W-1:0] rsel;
  logic [NUM_WIN-1:0]            hit;
  logic [ADDR_W-1:0]             addr_q;

  always_ff @(posedge clk) begin
    if (rst) addr_q <= '0;
    else     addr_q <= bus_addr_i;
  end

  csd_regfile #(.NUM_WIN(NUM_WIN), .REG_W(REG_W), .RA_W(RA_W)) u_regs (
    .clk(clk), .rst(rst), .ext_access_i(ext_access_i), .boot_cfg_i(boot_cfg_i),
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .ctl_o(ctl), .rsel_o(rsel)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    csd_window_match #(.ADDR_W(ADDR_W), .PAGE_LOG2(PAGE_LOG2), .SIZE_W(SIZE_W),
                       .REG_W(REG_W)) u_match (
      .rsel_i(rsel[g]), .active_i(ctl[g+1][CTL_ACT]), .addr_i(addr_q), .hit_o(hit[g])
    );

    // R5
    win_claims_addr_chk: assert property (@(posedge clk) disable iff (rst)
      !cs_n_o[g+1] |-> hit[g]);

    // R7
    rd_gate_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs_n_o[g+1] && ctl[g+1][CTL_RDCS] && !ctl[g+1][CTL_WRCS]) |-> !rd_n_i);

    // R8
    wr_gate_only_chk: assert property (@(posedge clk) disable iff (rst)
      (!cs_n_o[g+1] && ctl[g+1][CTL_WRCS] && !ctl[g+1][CTL_RDCS]) |-> !(&wr_n_i));
  end

  csd_select #(.NUM_WIN(NUM_WIN), .REG_W(REG_W)) u_sel (
    .hit_i(hit), .ctl_i(ctl), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i), .cs_n_o(cs_n_o)
  );

  // R10
  single_select_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_o));

  // R9
  default_only_unclaimed_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o[0] |-> (hit == '0 && ctl[0][CTL_ACT]));
endmodule

// File: tb/test_cs_window_decoder.sv
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_access = 1'b1;
  logic [1:0]  boot_cfg = 2'b00;
  logic        we = 1'b0;
  logic [3:0]  raddr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [23:0] baddr = '0;
  logic        rd_n = 1'b1;
  logic [1:0]  wr_n = 2'b11;
  logic [4:0]  cs_n;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_ctl [0:4];
  logic [15:0] m_rs  [1:4];

  always #5 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk(clk), .rst(rst), .ext_access_i(ext_access), .boot_cfg_i(boot_cfg),
    .reg_we_i(we), .reg_addr_i(raddr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .bus_addr_i(baddr), .rd_n_i(rd_n), .wr_n_i(wr_n), .cs_n_o(cs_n)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input logic [23:0] a, input logic rdn, input logic [1:0] wrn);
    int sel = -1;
    logic [15:0] c;
    logic q;
    for (int i = 1; i <= 4; i++) begin
      int n = int'(m_rs[i][3:0]);
      if (n > 12) n = 12;
      if (sel < 0 && m_ctl[i][0] && ((a[23:12] ^ m_rs[i][15:4]) >> n) == 12'h000) sel = i;
    end
    if (sel < 0) begin
      if (!m_ctl[0][0]) return 5'h1F;
      sel = 0;
    end
    c = m_ctl[sel];
    q = (!c[4] && !c[5]) || (c[4] && !rdn) || (c[5] && wrn != 2'b11);
    return q ? ~(5'd1 << sel) : 5'h1F;
  endfunction

  task automatic do_reset(input logic ext, input logic [1:0] cfg);
    @(negedge clk);
    rst = 1'b1; ext_access = ext; boot_cfg = cfg;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 1; i <= 4; i++) begin m_ctl[i] = '0; m_rs[i] = '0; end
    m_ctl[0] = ext ? 16'h0000 : {12'h000, cfg, 2'b11};
  endtask

  task automatic wreg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    we = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a <= 4) m_ctl[a] = d;
    else if (a >= 9 && a <= 12) m_rs[a - 8] = d;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    raddr = a;
    #1 d = rdata;
  endtask

  task automatic sweep(input string req, input bit vary_strobes);
    for (int p = 0; p < 4096; p++) begin
      int ph = vary_strobes ? (p % 4) : 0;
      @(negedge clk);
      baddr = {p[11:0], 12'(p * 37)};
      rd_n = (ph != 1);
      wr_n = (ph == 2) ? 2'b10 : (ph == 3) ? 2'b01 : 2'b11;
      @(posedge clk); #2;
      check(req, {27'd0, cs_n}, {27'd0, model(baddr, rd_n, wr_n)});
    end
  endtask

  initial begin
    #1_500_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    // R1, R2: ext-access high
    do_reset(1'b1, 2'b11);
    for (int a = 0; a <= 12; a++) begin
      if (a <= 4 || a >= 9) begin
        rreg(4'(a), d);
        check(a == 0 ? "R2 default ctl" : "R1 reg reset", {16'd0, d}, 32'd0);
      end
    end
    @(negedge clk); baddr = 24'h5A5A5A;
    @(posedge clk); #2;
    check("R2 no select", {27'd0, cs_n}, 32'h1F);

    // R3: ext-access low
    do_reset(1'b0, 2'b10);
    rreg(4'd0, d);
    check("R3 default ctl", {16'd0, d}, 32'h000B);
    @(negedge clk); baddr = 24'h123456;
    @(posedge clk); #2;
    check("R3 default active", {27'd0, cs_n}, 32'h1E);

    // R13: write takes effect at next edge
    @(negedge clk); we = 1'b1; raddr = 4'd9; wdata = {12'h123, 4'h0};
    @(posedge clk); #2;
    check("R13 before ctl", {27'd0, cs_n}, 32'h1E);
    @(negedge clk); raddr = 4'd1; wdata = 16'h0001;
    @(posedge clk); #2;
    we = 1'b0; m_rs[1] = {12'h123, 4'h0}; m_ctl[1] = 16'h0001;
    check("R13 after edge", {27'd0, cs_n}, 32'h1D);

    // R4, R6, R9: disjoint windows, window 4 disabled
    wreg(4'd9,  {12'h010, 4'h2});  wreg(4'd1, 16'h0001);
    wreg(4'd10, {12'h123, 4'h0});  wreg(4'd2, 16'h0001);
    wreg(4'd11, {12'h400, 4'h5});  wreg(4'd3, 16'h0001);
    wreg(4'd12, {12'h800, 4'h8});  wreg(4'd4, 16'h0000);
    sweep("R4 R6 R9 disjoint", 1'b0);

    // R5, R11: overlap, unaligned start, whole-space window
    wreg(4'd11, {12'h013, 4'h4});
    wreg(4'd12, {12'hABC, 4'hD});  wreg(4'd4, 16'h0001);
    sweep("R5 R11 overlap", 1'b0);

    // R7, R8: strobe gating
    wreg(4'd4, 16'h0000);
    wreg(4'd1, 16'h0011);
    wreg(4'd2, 16'h0021);
    wreg(4'd3, 16'h0031);
    wreg(4'd0, 16'h0013);
    sweep("R7 R8 R10 gating", 1'b1);

    // R12: unmapped addresses ignored
    wreg(4'd8,  16'hFFFF);
    wreg(4'd15, 16'hFFFF);
    wreg(4'd6,  16'hFFFF);
    for (int a = 0; a <= 12; a++) begin
      if (a <= 4 || a >= 9) begin
        rreg(4'(a), d);
        check("R12 unchanged", {16'd0, d}, {16'd0, (a <= 4) ? m_ctl[a] : m_rs[a - 8]});
      end
    end
    rreg(4'd8, d);
    check("R12 unmapped reads zero", {16'd0, d}, 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule